// File: doc/BRIEF.md
# Filtered Tamper Input Detector

This block watches one tamper pin on a slow kernel clock. It has two detection styles. In edge mode the block raises an event as soon as the pin moves to its active level. In filtered level mode the pin is sampled at a programmable rate, and an event is raised only after a run of consecutive samples all show the active level. In level mode a pull-up is driven for a short precharge window ahead of every sample. This lets a pin with a large capacitance settle before it is read.

An event gives a one-cycle pulse. It also sets a sticky flag, and the flag blocks further detection until an external strobe clears it. A mask option applies in filtered level mode only. With the mask set, the flag is never raised and the detector re-arms by itself, so a tamper that persists gives a periodic train of trigger pulses that other logic can consume without software help. The pin input is expected to be synchronised already.

Top module: `tamper_filt`

## Requirements
- R1: With `flt` = 0 (edge mode), a change of the pin to the active level raises `evt` for one cycle, visible after the next clock edge. `pol_low` = 0 makes high the active level; `pol_low` = 1 makes low the active level.
- R2: In edge mode `pu_en` stays 0.
- R3: If edge mode is enabled while the pin already sits at the active level, `evt` is raised after the first clock edge following the enable.
- R4: `flt` codes 1, 2 and 3 need 2, 4 and 8 consecutive active samples. Counting from the first edge after enable, a pin held active gives `evt` after edge N*P, where N is the sample count and P is the sample period.
- R5: The sample period is P = 2^(RATE_BASE - `rate`) kernel clock cycles, with `rate` in 0..7.
- R6: In level mode `pu_en` is high for the last min(2^`prch`, P) cycles of every sample period. `pu_dis` = 1 keeps `pu_en` at 0.
- R7: A sample taken at the inactive level clears the consecutive-sample count.
- R8: While `en` = 0 the block raises no `evt` and keeps `pu_en` at 0.
- R9: With the mask inactive, an event sets `flag`. `flag` holds until a `flag_clr` strobe clears it, and no event is raised while `flag` is set.
- R10: In level mode with `mask` = 1, `flag` stays 0 and a pin held active yields an `evt` pulse every N*P cycles.
- R11: In edge mode `mask` has no effect: an event still sets `flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin | input | 1 | Synchronised tamper pin level |
| en | input | 1 | Detector enable |
| pol_low | input | 1 | 0: high/rising is active, 1: low/falling is active |
| flt | input | 2 | 0 selects edge mode; 1..3 select 2/4/8-sample level mode |
| rate | input | 3 | Sample period code, P = 2^(RATE_BASE-rate) |
| prch | input | 2 | Precharge length code, 2^prch cycles |
| pu_dis | input | 1 | Disables the precharge pull-up |
| mask | input | 1 | Self-rearming trigger mode (level mode only) |
| flag_clr | input | 1 | Strobe that clears the sticky flag |
| pu_en | output | 1 | Pull-up enable for the pad |
| evt | output | 1 | One-cycle event / trigger pulse |
| flag | output | 1 | Sticky tamper flag |

## Verification
The bench sweeps every filter code against every rate code and measures the cycle of the first event, so any off-by-one in the timebase or the sample counter shows up as a wrong latency. Precharge length is swept against short and long periods, including windows longer than the period, because a design that clamps wrongly gives the wrong count of pull-up cycles. The bench drops the pin for exactly one sample in the middle of a run; a counter that is not cleared then fires one period early. Other cases are arming onto an already-active pin, detection blocked while the flag is set, and the mask in both modes. A design that honours the mask in edge mode would leave the flag clear, and one that fails to re-arm would give a single pulse where a train is expected.

// File: rtl/tamper_filt.sv
module tamper_filt #(
  parameter int RATE_BASE = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic       en,
  input  logic       pol_low,
  input  logic [1:0] flt,
  input  logic [2:0] rate,
  input  logic [1:0] prch,
  input  logic       pu_dis,
  input  logic       mask,
  input  logic       flag_clr,
  output logic       pu_en,
  output logic       evt,
  output logic       flag
);
  localparam int PW = RATE_BASE + 1;

  logic          lvl, lvl_mode, edge_mode, mask_eff;
  logic [PW-1:0] per, tcnt, rem, wlen;
  logic          tick;
  logic [3:0]    need, scnt;
  logic          prev_act;
  logic          det_edge, det_lvl, det;

  assign lvl       = pin ^ pol_low;
  assign lvl_mode  = en && (flt != 2'd0);
  assign edge_mode = en && (flt == 2'd0);
  assign mask_eff  = mask && (flt != 2'd0);

  assign per  = PW'(1) << (RATE_BASE - 32'(rate));
  assign wlen = PW'(1) << prch;
  assign rem  = per - PW'(1) - tcnt;
  assign tick = lvl_mode && (tcnt >= per - PW'(1));
  assign need = 4'd1 << flt;

  assign pu_en = lvl_mode && !pu_dis && (rem < wlen);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     tcnt <= '0;
    else if (!lvl_mode || tick)     tcnt <= '0;
    else                            tcnt <= tcnt + PW'(1);

  assign det_lvl = tick && !flag && lvl && (scnt + 4'd1 >= need);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     scnt <= '0;
    else if (!lvl_mode || flag)     scnt <= '0;
    else if (tick)                  scnt <= (lvl && !det_lvl) ? scnt + 4'd1 : 4'd0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_act <= 1'b0;
    else        prev_act <= edge_mode ? lvl : 1'b0;

  assign det_edge = edge_mode && lvl && !prev_act && !flag;
  assign det      = det_edge || det_lvl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      evt  <= 1'b0;
      flag <= 1'b0;
    end else begin
      evt <= det;
      if (det && !mask_eff) flag <= 1'b1;
      else if (flag_clr)    flag <= 1'b0;
    end

  a_r2_edge_no_pullup: assert property (@(posedge clk) disable iff (!rst_n)
    (en && flt == 2'd0) |-> !pu_en);
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !evt);
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);
  a_r9_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    flag |=> !evt);
  a_r10_mask_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (mask && flt != 2'd0 && !flag) |=> !flag);
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
endmodule

// File: tb/sim_tamper_filt.sv
module sim_tamper_filt;
  localparam int RB = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pin = 0, en = 0, pol_low = 0, pu_dis = 0, mask = 0, flag_clr = 0;
  logic [1:0] flt = 0, prch = 0;
  logic [2:0] rate = 0;
  logic pu_en, evt, flag;
  int errors = 0, checks = 0;
  int cyc = 0;

  tamper_filt #(.RATE_BASE(RB)) u0 (.clk(clk), .rst_n(rst_n), .pin(pin), .en(en),
    .pol_low(pol_low), .flt(flt), .rate(rate), .prch(prch), .pu_dis(pu_dis),
    .mask(mask), .flag_clr(flag_clr), .pu_en(pu_en), .evt(evt), .flag(flag));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic idle();
    en = 0; mask = 0; flag_clr = 1; step(); flag_clr = 0; step();
  endtask

  task automatic wait_evt(input int maxc, output int got);
    got = -1;
    for (int i = 1; i <= maxc; i++) begin
      step();
      if (evt) begin got = i; return; end
    end
  endtask

  int got, n, p, w, cnt;

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    step();
    check("R9 reset flag", flag, 0);
    check("R1 reset evt", evt, 0);
    check("R8 reset pu_en", pu_en, 0);

    // R1 edge, both polarities; R2 no pull-up; R9 blocking and clear
    for (int pl = 0; pl < 2; pl++) begin
      idle();
      pol_low = pl[0]; flt = 0; pin = pl[0]; en = 1; step();
      check("R2 edge pu_en", pu_en, 0);
      check("R1 idle no evt", evt, 0);
      pin = ~pl[0]; step();
      check("R1 edge evt", evt, 1);
      check("R9 flag set", flag, 1);
      step();
      check("R1 one pulse", evt, 0);
      pin = pl[0]; step(); pin = ~pl[0];
      wait_evt(6, got);
      check("R9 blocked while flag", got, -1);
      check("R9 flag held", flag, 1);
      pin = pl[0]; flag_clr = 1; step(); flag_clr = 0;
      check("R9 flag cleared", flag, 0);
      pin = ~pl[0]; step();
      check("R9 rearmed evt", evt, 1);
    end

    // R3 arming onto active pin
    idle(); pol_low = 0; flt = 0; pin = 1; en = 1; step();
    check("R3 armed on active", evt, 1);

    // R11 mask ignored in edge mode
    idle(); pin = 0; mask = 1; flt = 0; en = 1; step(); pin = 1; step();
    check("R11 edge evt", evt, 1);
    check("R11 flag set despite mask", flag, 1);

    // R8 disabled
    idle(); pin = 0; flt = 2; rate = 7;
    for (int i = 0; i < 20; i++) begin
      pin = i[0]; step();
      cnt = cnt + (evt ? 1 : 0) + (pu_en ? 1 : 0);
    end
    check("R8 disabled quiet", cnt, 0);

    // R4 R5 sweep of filter and rate
    for (int f = 1; f < 4; f++)
      for (int r = 0; r < 8; r++) begin
        idle(); pol_low = 0; pin = 1; flt = f[1:0]; rate = r[2:0]; en = 1;
        n = 1 << f; p = 1 << (RB - r);
        wait_evt(n * p + 4, got);
        check($sformatf("R4 R5 latency f=%0d r=%0d", f, r), got, n * p);
      end

    // R6 precharge window sweep
    for (int r = 4; r < 8; r += 2)
      for (int c = 0; c < 4; c++)
        for (int d = 0; d < 2; d++) begin
          idle(); pin = 0; flt = 1; rate = r[2:0]; prch = c[1:0]; pu_dis = d[0]; en = 1;
          p = 1 << (RB - r); w = 1 << c; if (w > p) w = p;
          repeat (p) step();
          cnt = 0;
          for (int i = 0; i < 4 * p; i++) begin step(); if (pu_en) cnt++; end
          check($sformatf("R6 pullup r=%0d c=%0d d=%0d", r, c, d), cnt, d ? 0 : 4 * w);
        end
    pu_dis = 0;

    // R7 an inactive sample restarts the count
    idle(); pin = 1; flt = 1; rate = 6; en = 1; p = 4;
    repeat (p) step();
    pin = 0; repeat (p) step(); pin = 1;
    wait_evt(4 * p, got);
    check("R7 restart after inactive sample", got + 2 * p, 4 * p);

    // R10 masked level mode pulse train
    idle(); pin = 1; flt = 1; rate = 6; mask = 1; en = 1;
    cnt = 0; got = 0;
    for (int i = 1; i <= 3 * 8 + 2; i++) begin
      step(); if (evt) cnt++; if (flag) got = 1;
    end
    check("R10 masked pulse count", cnt, 3);
    check("R10 masked flag low", got, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule